// File: doc/BRIEF.md
# Packed Integer Lane Width Converter

This block converts a 64-bit word of packed integer lanes from one element width to another. When the destination is narrower, each source lane is either chopped to its low bits or clamped to the range of the destination type. When the destination is wider, each source lane is sign-extended or zero-extended. Whether narrowing clamps or chops comes from a persistent saturation-mode register written through a small configuration port, in the way a rounding mode is held. It is not chosen per request.

A request is accepted while the converter is idle. It then walks the lanes one per cycle and presents the packed result for one cycle. Any clamp raises a sticky saturation flag, which only an explicit clear drops.

The sequencer has three states. IDLE accepts a request (transition IDLE to RUN on `in_valid`). RUN converts one lane per cycle (RUN to DONE after the last lane). DONE presents the result (DONE to IDLE unconditionally).

Top module: `lane_width_conv`

## Requirements
- R1: Width codes are 0=8, 1=16, 2=32, 3=64 bits. A request is taken when `in_valid` and `in_ready` are both high. The converter handles 64/max(src,dst) lanes, one per cycle. `out_valid` is high for exactly one cycle and carries the result in `out_word`.
- R2: In chop mode (saturation mode 0), narrowing keeps the low destination-width bits of each source lane.
- R3: In saturate mode with a signed source and a signed destination, a lane clamps to [-2^(M-1), 2^(M-1)-1], where M is the destination width.
- R4: In saturate mode with an unsigned source and an unsigned destination, a lane is read as unsigned and clamps to 2^M-1. With a signed destination, it clamps to 2^(M-1)-1.
- R5: In saturate mode with a signed source and an unsigned destination, a negative lane clamps to 0 and an oversized positive lane clamps to 2^M-1.
- R6: When widening, each lane is sign-extended if `in_src_signed` is 1 and zero-extended otherwise. The saturation mode and `in_dst_signed` have no effect, and the flag is not set.
- R7: Narrowed lanes are packed contiguously from bit 0, and all bits above the last lane are zero.
- R8: `sat_flag` is set when any lane clamps and stays set until `flag_clr` is pulsed. If a clamp and a clear fall in the same cycle, the flag ends up set.
- R9: The saturation mode resets to 0 (chop) and is written by `cfg_we`/`cfg_sat`. Each request uses the mode in force at its acceptance, so a write during a conversion affects only later requests.
- R10: When the source and destination widths are equal, the word is copied unchanged and the flag is not set.
- R11: After reset, `in_ready` is 1, `out_valid` is 0, `out_word` is 0 and `sat_flag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the saturation mode |
| cfg_sat | input | 1 | New saturation mode: 1 clamp, 0 chop |
| flag_clr | input | 1 | Clears the sticky saturation flag |
| in_valid | input | 1 | Request strobe |
| in_ready | output | 1 | High while idle |
| in_word | input | 64 | Packed source lanes |
| in_src_w | input | 2 | Source width code |
| in_dst_w | input | 2 | Destination width code |
| in_src_signed | input | 1 | Source lanes are signed |
| in_dst_signed | input | 1 | Destination range is signed |
| out_valid | output | 1 | Result strobe, one cycle |
| out_word | output | 64 | Packed result |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
The bench checks the clamp limits exactly at the boundary: values just inside the range and just outside it. A design with an off-by-one limit or a flipped signed compare would pass one of these and fail the other. It feeds negative signed lanes into an unsigned destination and large unsigned lanes into a signed destination. A design that mixes up source and destination signedness would return the maximum where zero is due, or the reverse. It changes the mode while a conversion is in flight, and pulses clear in the same cycle as a clamp. A design that samples the mode late, or lets clear win, would return chopped lanes or a dropped flag. Widening is run with saturate mode on to show that the extension is untouched.

// File: rtl/lwc_pkg.sv
package lwc_pkg;

    typedef enum logic [1:0] {
        LWC_IDLE = 2'd0,
        LWC_RUN  = 2'd1,
        LWC_DONE = 2'd2
    } lwc_state_e;

    // number of lanes handled for a pair of width codes
    function automatic int lane_count(input int word_w, input int min_w,
                                      input int src_code, input int dst_code);
        int widest;
        widest = (src_code > dst_code) ? src_code : dst_code;
        return (word_w / min_w) >> widest;
    endfunction

endpackage

// File: rtl/lwc_lane_conv.sv
module lwc_lane_conv #(
    parameter int WORD_W = 64,
    parameter int MIN_W  = 8,
    parameter int CODE_W = 2,
    parameter int IDX_W  = 3
) (
    input  logic [WORD_W-1:0] src_word,
    input  logic [IDX_W-1:0]  lane_idx,
    input  logic [CODE_W-1:0] src_code,
    input  logic [CODE_W-1:0] dst_code,
    input  logic              src_signed,
    input  logic              dst_signed,
    input  logic              sat_en,
    output logic [WORD_W-1:0] lane_out,
    output logic              clamped
);
    localparam int XW = WORD_W + 1;

    int              sw;
    int              dw;
    int              sh;
    logic            narrow;
    logic [XW-1:0]   smask;
    logic [WORD_W-1:0] dmask;
    logic [XW-1:0]   raw;
    logic [XW-1:0]   ext;
    logic [XW-1:0]   hi;
    logic [XW-1:0]   lo;

    always_comb begin
        sw     = MIN_W << src_code;
        dw     = MIN_W << dst_code;
        sh     = int'(lane_idx) * sw;
        narrow = (dst_code < src_code);
        smask  = (XW'(1) << sw) - XW'(1);
        dmask  = (dw >= WORD_W) ? '1 : ((WORD_W'(1) << dw) - WORD_W'(1));
        raw    = XW'(src_word >> sh) & smask;
        ext    = raw;
        if (src_signed && raw[sw-1]) begin
            ext = raw | ~smask;
        end
        if (dst_signed) begin
            hi = (XW'(1) << (dw - 1)) - XW'(1);
            lo = ~hi;
        end else begin
            hi = (XW'(1) << dw) - XW'(1);
            lo = '0;
        end
        clamped  = 1'b0;
        lane_out = narrow ? (raw[WORD_W-1:0] & dmask) : (ext[WORD_W-1:0] & dmask);
        if (narrow && sat_en) begin
            if ($signed(ext) > $signed(hi)) begin
                lane_out = hi[WORD_W-1:0] & dmask;
                clamped  = 1'b1;
            end else if ($signed(ext) < $signed(lo)) begin
                lane_out = lo[WORD_W-1:0] & dmask;
                clamped  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/lwc_sticky.sv
module lwc_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
        end else if (set_i) begin
            flag_o <= 1'b1;
        end else if (clr_i) begin
            flag_o <= 1'b0;
        end
    end

    assert_flag_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flag_o && !clr_i |=> flag_o);

    assert_flag_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i && !set_i |=> !flag_o);

endmodule

// File: rtl/lwc_mode_reg.sv
module lwc_mode_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic we,
    input  logic din,
    output logic mode_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_o <= 1'b0;
        end else if (we) begin
            mode_o <= din;
        end
    end

    assert_mode_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(mode_o));

endmodule

// File: rtl/lane_width_conv.sv
module lane_width_conv
    import lwc_pkg::*;
#(
    parameter int WORD_W = 64,
    parameter int MIN_W  = 8,
    localparam int NLANE_MAX = WORD_W / MIN_W,
    localparam int IDX_W  = $clog2(NLANE_MAX),
    localparam int CODE_W = $clog2($clog2(NLANE_MAX) + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sat,
    input  logic              flag_clr,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_word,
    input  logic [CODE_W-1:0] in_src_w,
    input  logic [CODE_W-1:0] in_dst_w,
    input  logic              in_src_signed,
    input  logic              in_dst_signed,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_word,
    output logic              sat_flag
);
    lwc_state_e        state;
    lwc_state_e        state_nx;

    logic [WORD_W-1:0] op_word;
    logic [CODE_W-1:0] op_src;
    logic [CODE_W-1:0] op_dst;
    logic              op_ss;
    logic              op_ds;
    logic              op_sat;
    logic [IDX_W-1:0]  idx;
    logic [IDX_W-1:0]  last_idx;
    logic [WORD_W-1:0] acc;

    logic              sat_mode;
    logic              accept;
    logic              lane_step;
    logic [WORD_W-1:0] lane_out;
    logic              lane_clamped;
    logic [WORD_W-1:0] placed;
    logic [WORD_W-1:0] used_mask;
    int                used_bits;

    lwc_mode_reg u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .din    (cfg_sat),
        .mode_o (sat_mode)
    );

    lwc_lane_conv #(
        .WORD_W (WORD_W),
        .MIN_W  (MIN_W),
        .CODE_W (CODE_W),
        .IDX_W  (IDX_W)
    ) u_lane (
        .src_word   (op_word),
        .lane_idx   (idx),
        .src_code   (op_src),
        .dst_code   (op_dst),
        .src_signed (op_ss),
        .dst_signed (op_ds),
        .sat_en     (op_sat),
        .lane_out   (lane_out),
        .clamped    (lane_clamped)
    );

    lwc_sticky u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (lane_step && lane_clamped),
        .clr_i  (flag_clr),
        .flag_o (sat_flag)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= LWC_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            LWC_IDLE: if (in_valid)        state_nx = LWC_RUN;
            LWC_RUN:  if (idx == last_idx) state_nx = LWC_DONE;
            LWC_DONE:                      state_nx = LWC_IDLE;
            default:                       state_nx = LWC_IDLE;
        endcase
    end

    // state outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        lane_step = 1'b0;
        unique case (state)
            LWC_IDLE: in_ready  = 1'b1;
            LWC_RUN:  lane_step = 1'b1;
            LWC_DONE: out_valid = 1'b1;
            default:  in_ready  = 1'b0;
        endcase
    end

    assign accept   = in_ready && in_valid;
    assign out_word = acc;

    always_comb begin
        placed = lane_out << (int'(idx) * (MIN_W << op_dst));
    end

    // operation registers and packing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_word  <= '0;
            op_src   <= '0;
            op_dst   <= '0;
            op_ss    <= 1'b0;
            op_ds    <= 1'b0;
            op_sat   <= 1'b0;
            idx      <= '0;
            last_idx <= '0;
            acc      <= '0;
        end else if (accept) begin
            op_word  <= in_word;
            op_src   <= in_src_w;
            op_dst   <= in_dst_w;
            op_ss    <= in_src_signed;
            op_ds    <= in_dst_signed;
            op_sat   <= sat_mode;
            idx      <= '0;
            last_idx <= IDX_W'(lane_count(WORD_W, MIN_W, int'(in_src_w), int'(in_dst_w)) - 1);
            acc      <= '0;
        end else if (lane_step) begin
            acc <= acc | placed;
            idx <= idx + IDX_W'(1);
        end
    end

    // span occupied by narrowed lanes, for the packing check
    always_comb begin
        used_bits = lane_count(WORD_W, MIN_W, int'(op_src), int'(op_dst)) * (MIN_W << op_dst);
        used_mask = (used_bits >= WORD_W) ? '1 : ((WORD_W'(1) << used_bits) - WORD_W'(1));
    end

    assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    assert_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (op_dst < op_src) |-> ((out_word & ~used_mask) == '0));

    assert_flag_rise_in_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sat_flag) |-> $past(state == LWC_RUN));

    assert_widen_no_clamp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lane_step && (op_dst >= op_src) |-> !lane_clamped);

endmodule

// File: tb/test_lane_width_conv.sv
module test_lane_width_conv;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_sat = 1'b0;
    logic        flag_clr = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] in_word = '0;
    logic [1:0]  in_src_w = '0;
    logic [1:0]  in_dst_w = '0;
    logic        in_src_signed = 1'b0;
    logic        in_dst_signed = 1'b0;
    logic        out_valid;
    logic [63:0] out_word;
    logic        sat_flag;

    int checks = 0;
    int errors = 0;
    bit mode_m = 1'b0;
    bit flag_m = 1'b0;
    bit finished = 1'b0;

    typedef struct {
        logic [63:0] res;
        bit          flag;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_width_conv i_lane_width_conv (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sat(cfg_sat),
        .flag_clr(flag_clr), .in_valid(in_valid), .in_ready(in_ready),
        .in_word(in_word), .in_src_w(in_src_w), .in_dst_w(in_dst_w),
        .in_src_signed(in_src_signed), .in_dst_signed(in_dst_signed),
        .out_valid(out_valid), .out_word(out_word), .sat_flag(sat_flag)
    );

    function automatic logic [63:0] model(input logic [63:0] w, input int sc, input int dc,
                                          input bit ss, input bit ds, input bit sat,
                                          output bit clamp);
        logic [63:0] res;
        int sw, dw, n;
        sw = 8 << sc;
        dw = 8 << dc;
        n  = 8 >> ((sc > dc) ? sc : dc);
        res = '0;
        clamp = 1'b0;
        for (int i = 0; i < n; i++) begin
            logic signed [64:0] v, mx, mn, r;
            v = '0;
            for (int b = 0; b < sw; b++) v[b] = w[i*sw + b];
            if (ss && w[i*sw + sw - 1])
                for (int b = sw; b < 65; b++) v[b] = 1'b1;
            r = v;
            if (dc < sc && sat) begin
                mx = ds ? ((65'sd1 <<< (dw-1)) - 65'sd1) : ((65'sd1 <<< dw) - 65'sd1);
                mn = ds ? -(65'sd1 <<< (dw-1)) : 65'sd0;
                if (v > mx) begin r = mx; clamp = 1'b1; end
                else if (v < mn) begin r = mn; clamp = 1'b1; end
            end
            for (int b = 0; b < dw; b++) res[i*dw + b] = r[b];
        end
        return res;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_op(input logic [63:0] w, input int sc, input int dc,
                         input bit ss, input bit ds, input string tag);
        exp_t e;
        bit cl;
        while (!in_ready) @(negedge clk);
        e.res  = model(w, sc, dc, ss, ds, mode_m, cl);
        flag_m = flag_m | cl;
        e.flag = flag_m;
        e.tag  = tag;
        sb.push_back(e);
        in_valid = 1'b1; in_word = w; in_src_w = 2'(sc); in_dst_w = 2'(dc);
        in_src_signed = ss; in_dst_signed = ds;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (sb.size() != 0 || !in_ready) @(negedge clk);
    endtask

    task automatic set_mode(input bit m);
        cfg_we = 1'b1; cfg_sat = m;
        @(negedge clk);
        cfg_we = 1'b0;
        mode_m = m;
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        flag_m = 1'b0;
        check(sat_flag == 1'b0, "R8 clear", 64'(sat_flag), 64'd0);
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R1 unexpected result", out_word, 64'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(out_word == e.res, e.tag, out_word, e.res);
                check(sat_flag == e.flag, {e.tag, " flag R8"}, 64'(sat_flag), 64'(e.flag));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1,  "R11 in_ready",  64'(in_ready),  64'd1);
        check(out_valid == 1'b0, "R11 out_valid", 64'(out_valid), 64'd0);
        check(out_word == '0,    "R11 out_word",  out_word,        64'd0);
        check(sat_flag == 1'b0,  "R11 sat_flag",  64'(sat_flag),  64'd0);

        // R9 reset mode is chop; R2 truncation on each narrowing pair
        do_op(64'h1234_5678_9ABC_DEF0, 3, 2, 1, 1, "R2 64to32 chop");
        do_op(64'h8001_7FFE_0123_FF80, 2, 1, 1, 1, "R2 32to16 chop");
        do_op(64'hF00F_0180_7F7F_8001, 1, 0, 1, 1, "R2 R7 16to8 chop");
        wait_idle();

        set_mode(1'b1);
        // R3 signed boundaries
        do_op(64'h0000_0000_7FFF_FFFF, 3, 2, 1, 1, "R3 64to32 max inside");
        do_op(64'hFFFF_FFFF_8000_0000, 3, 2, 1, 1, "R3 64to32 min inside");
        wait_idle();
        check(sat_flag == 1'b0, "R3 no clamp inside", 64'(sat_flag), 64'd0);
        do_op(64'h0000_0000_8000_0000, 3, 2, 1, 1, "R3 64to32 over");
        do_op(64'h007F_0080_FF80_FF7F, 1, 0, 1, 1, "R3 R7 16to8 mixed");
        do_op(64'h8000_0000_7FFF_8000, 2, 1, 1, 1, "R3 32to16");
        // R4 unsigned source
        do_op(64'hFFFF_0000_0000_1234, 2, 1, 0, 0, "R4 32to16 unsigned");
        do_op(64'h8000_0000_0000_7FFF, 2, 1, 0, 1, "R4 unsigned to signed");
        do_op(64'h00FF_0100_FFFF_0001, 1, 0, 0, 0, "R4 16to8 unsigned");
        // R5 signed source, unsigned destination
        do_op(64'hFFFF_0100_007F_8000, 1, 0, 1, 0, "R5 16to8 neg to zero");
        do_op(64'hFFFF_FFFF_0001_0000, 3, 2, 1, 0, "R5 64to32 neg");
        wait_idle();
        clear_flag();
        // R6 widening with saturate on
        do_op(64'h0000_0000_80FF_7F01, 0, 1, 1, 0, "R6 8to16 sign");
        do_op(64'h0000_0000_80FF_7F01, 0, 2, 0, 1, "R6 8to32 zero");
        do_op(64'h0000_0000_0000_8001, 1, 3, 1, 1, "R6 16to64 sign");
        do_op(64'h0000_0000_8000_0001, 2, 3, 0, 0, "R6 32to64 zero");
        // R10 equal widths
        do_op(64'hFEDC_BA98_8000_7FFF, 2, 2, 1, 0, "R10 32to32 copy");
        do_op(64'h80FF_0011_2233_4455, 0, 0, 1, 0, "R10 8to8 copy");
        wait_idle();
        check(sat_flag == 1'b0, "R6 R10 flag untouched", 64'(sat_flag), 64'd0);

        // R8 sticky across a clean op
        do_op(64'h0000_0000_0000_0200, 1, 0, 1, 1, "R8 clamp");
        do_op(64'h0000_0000_0000_0011, 1, 0, 1, 1, "R8 clean after clamp");
        wait_idle();
        check(sat_flag == 1'b1, "R8 held", 64'(sat_flag), 64'd1);
        clear_flag();
        // R8 clear in the cycle lane 0 clamps: set wins
        do_op(64'h0000_0000_0000_0200, 1, 0, 1, 1, "R8 clear collides");
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        wait_idle();
        clear_flag();

        // R9 mode write during a conversion
        do_op(64'h0300_0200_0100_7FFF, 1, 0, 1, 1, "R9 sat latched");
        set_mode(1'b0);
        do_op(64'h0300_0200_0100_7FFF, 1, 0, 1, 1, "R9 chop after write");
        wait_idle();
        set_mode(1'b1);
        do_op(64'h0000_0000_0000_0200, 1, 0, 1, 1, "R9 sat restored");
        wait_idle();

        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule